// File: doc/BRIEF.md
# Indirect Word-Access Window for Core Instruction and Data Memories

This block gives a host a narrow register view into the two private memories of an embedded core: a data memory and an instruction memory. Each memory is reached through a pair of registers. A control register holds the current position, written as a byte address split into a 256-byte block number and a 32-bit word offset, together with separate enables that advance the position after every data read or every data write. A data register moves one 32-bit word per access. Loading or dumping a whole image therefore takes one control write followed by a run of data accesses.

Reads are prefetched. The word at the current position is already fetched when the host asks for it, so a data read placed right after a control write, or right after another data read, returns valid data with no wait. The instruction-memory side also keeps a tag and a secure mark for each 256-byte block. Both are recorded as the host fills the first word of that block. Consecutive blocks of a fill receive consecutive tags. A configuration register reports both memory sizes in blocks. An access outside the configured size, or a control write with a byte position that is not word aligned, raises a sticky error output.

Top module: `imp_top`

## Requirements
- R1: After a synchronous active-low reset, `rdata_o` and `err_o` are 0. Both control registers read 0. The tag view of instruction block 0 reads 0.
- R2: A control word carries the byte position in bits [15:2]: block number in [15:8] and word offset in [7:2]. Bit 24 enables advance on write and bit 25 enables advance on read. Reading a control register returns the current position in the same fields, with bits [1:0] always 0.
- R3: With bit 24 set, each in-range data write stores the word and moves the position one word forward. After n writes, the control register reads back the start position plus 4*n bytes.
- R4: With bit 25 set, each in-range data read moves the position one word forward. With an enable clear, repeated accesses of that kind stay on the same word.
- R5: A register read returns its value on `rdata_o` in the cycle after the request. A data read issued in the cycle right after a control write or a data write returns the word now at the position. Back-to-back data reads return consecutive words.
- R6: Advancing from the last word of the configured memory (block count times 64 words) wraps the position to byte 0.
- R7: A data access at or beyond the configured size has these effects: a write is dropped without aliasing onto any stored word, a read returns 0, the position does not move, and `err_o` goes to 1 and stays at 1 until reset.
- R8: A control write whose bits [1:0] are not zero sets the sticky error. The position loads with those two bits cleared.
- R9: Bit 28 of the instruction-memory control word is the secure mark and reads back there. Bit 28 of the data-memory control word always reads 0.
- R10: A write to the tag register sets the next tag. Each in-range instruction-memory data write at word offset 0 records the next tag and the current secure mark for that block, then increments the next tag. Reading the tag register returns, for the block at the current instruction-memory position, the tag in bits [TAG_W-1:0] and the secure mark in bit 31.
- R11: The configuration register reads the data-memory block count in bits [15:0] and the instruction-memory block count in bits [31:16].
- R12: The two memories keep independent positions, modes and contents. Register selects: 0 data control, 1 data word, 2 instruction control, 3 instruction word, 4 tag, 5 configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Register access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_i | input | 3 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| err_o | output | 1 | Sticky illegal-access flag |

## Verification
Fills and dumps are exercised with the advance on write only, the advance on read only, and neither enabled. Comparing the control readback and the returned words across these runs shows whether each enable acts on its own side alone. Paced reads and back-to-back reads, including a read right after a write to the same word, show whether the prefetch follows the position and newly written data. A 65-word instruction fill that crosses a block boundary checks the tag sequence and the secure mark per block. Accesses at the last word, one block past the end, and at a misaligned byte position separate correct wrap from aliasing, and a dropped access from a silent one.

// File: rtl/imp_pkg.sv
// Package: shared field positions and register selects of the indirect
// memory window. Assumes a 32-bit host register path.
package imp_pkg;
    localparam int CA_W        = 14;   // word position width, byte bits [15:2]
    localparam int POS_LO      = 2;
    localparam int POS_HI      = 15;
    localparam int BIT_ADV_WR  = 24;
    localparam int BIT_ADV_RD  = 25;
    localparam int BIT_SECURE  = 28;
    localparam int WORDS_PER_BLK = 64;

    localparam logic [2:0] SEL_DCTL = 3'd0;
    localparam logic [2:0] SEL_DDAT = 3'd1;
    localparam logic [2:0] SEL_ICTL = 3'd2;
    localparam logic [2:0] SEL_IDAT = 3'd3;
    localparam logic [2:0] SEL_TAG  = 3'd4;
    localparam logic [2:0] SEL_CFG  = 3'd5;

    typedef struct packed {
        logic secure;
        logic adv_rd;
        logic adv_wr;
    } imp_mode_t;
endpackage

// File: rtl/imp_tag_table.sv
// Per-block tag and secure-mark store. It holds a running "next tag" that the
// host sets. On each fill event the tag goes to the addressed block and the
// next tag increments. Assumes BLOCKS >= 2, TAG_W <= 31 and block indices
// below 256.
module imp_tag_table #(
    parameter int BLOCKS = 4,
    parameter int TAG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [TAG_W-1:0] set_val_i,
    input  logic             fill_i,
    input  logic [7:0]       fill_blk_i,
    input  logic             fill_sec_i,
    input  logic [7:0]       look_blk_i,
    output logic [31:0]      entry_o
);
    localparam int BI_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;

    logic [TAG_W-1:0] next_q;
    logic [TAG_W-1:0] tag_q [BLOCKS];
    logic             sec_q [BLOCKS];
    logic             look_ok;

    // Purpose: keep the running tag and record it per block on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_q <= '0;
            for (int b = 0; b < BLOCKS; b++) begin
                tag_q[b] <= '0;
                sec_q[b] <= 1'b0;
            end
        end else if (set_i) begin
            next_q <= set_val_i;
        end else if (fill_i && (32'(fill_blk_i) < 32'(BLOCKS))) begin
            tag_q[fill_blk_i[BI_W-1:0]] <= next_q;
            sec_q[fill_blk_i[BI_W-1:0]] <= fill_sec_i;
            next_q <= next_q + 1'b1;
        end
    end

    // Purpose: present the tag view of the looked-up block.
    always_comb begin
        look_ok = 32'(look_blk_i) < 32'(BLOCKS);
        entry_o = '0;
        if (look_ok) begin
            entry_o[31]        = sec_q[look_blk_i[BI_W-1:0]];
            entry_o[TAG_W-1:0] = tag_q[look_blk_i[BI_W-1:0]];
        end
    end

    // R10: every in-range fill moves the running tag forward by one
    assert_tag_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !set_i && (32'(fill_blk_i) < 32'(BLOCKS)))
        |=> next_q == $past(next_q) + 1'b1);
endmodule

// File: rtl/imp_window.sv
// One indirect access window: control register (position and modes), data
// register with prefetch, internal word RAM and sticky error. With IS_CODE
// set it also keeps the secure mark and feeds the tag table. Assumes one
// host request per cycle and BLOCKS between 2 and 256.
module imp_window
    import imp_pkg::*;
#(
    parameter int         BLOCKS  = 4,
    parameter bit         IS_CODE = 1'b0,
    parameter int         TAG_W   = 16,
    parameter logic [2:0] CTL_IDX = SEL_DCTL,
    parameter logic [2:0] DAT_IDX = SEL_DDAT,
    parameter logic [2:0] TAG_IDX = SEL_TAG
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [2:0]  reg_i,
    input  logic [31:0] wdata_i,
    output logic        rd_hit_o,
    output logic [31:0] rd_val_o,
    output logic        err_o
);
    localparam int WORDS = BLOCKS * WORDS_PER_BLK;
    localparam int WA_W  = $clog2(WORDS);
    localparam logic [CA_W-1:0] LAST = CA_W'(WORDS - 1);

    logic [CA_W-1:0] pos_q, pos_d;
    imp_mode_t       mode_q, mode_d;
    logic            err_q, err_d;
    logic [31:0]     pf_q;
    logic [31:0]     mem [WORDS];

    logic ctl_sel, dat_sel, tag_sel;
    logic ctl_wr, dat_wr, dat_rd, tag_wr;
    logic in_range, nxt_in_range, advance, fill;
    logic [CA_W-1:0] pos_inc;
    logic [31:0] ctl_view, tag_view;
    logic        sec_in;

    // Purpose: decode the host request for this window.
    always_comb begin
        ctl_sel = req_i && (reg_i == CTL_IDX);
        dat_sel = req_i && (reg_i == DAT_IDX);
        tag_sel = IS_CODE && req_i && (reg_i == TAG_IDX);
        ctl_wr  = ctl_sel && we_i;
        dat_wr  = dat_sel && we_i;
        dat_rd  = dat_sel && !we_i;
        tag_wr  = tag_sel && we_i;
    end

    // Purpose: range check, wrap-around increment and next position/mode.
    always_comb begin
        in_range = 32'(pos_q) < 32'(WORDS);
        pos_inc  = (pos_q == LAST) ? '0 : pos_q + 1'b1;
        advance  = in_range && ((dat_wr && mode_q.adv_wr) || (dat_rd && mode_q.adv_rd));
        pos_d    = pos_q;
        mode_d   = mode_q;
        if (ctl_wr) begin
            pos_d         = wdata_i[POS_HI:POS_LO];
            mode_d.adv_wr = wdata_i[BIT_ADV_WR];
            mode_d.adv_rd = wdata_i[BIT_ADV_RD];
            mode_d.secure = sec_in;
        end else if (advance) begin
            pos_d = pos_inc;
        end
        nxt_in_range = 32'(pos_d) < 32'(WORDS);
        err_d = err_q || (ctl_wr && (wdata_i[1:0] != 2'b00))
                      || ((dat_wr || dat_rd) && !in_range);
        fill  = dat_wr && in_range && (pos_q[5:0] == 6'd0);
    end

    // Secure mark exists only on the instruction-memory window.
    generate
        if (IS_CODE) begin : g_sec
            assign sec_in = wdata_i[BIT_SECURE];
        end else begin : g_nosec
            assign sec_in = 1'b0;
        end
    endgenerate

    // Purpose: position, mode and sticky error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            mode_q <= mode_d;
            err_q  <= err_d;
        end
    end

    // Purpose: word RAM write port, in-range writes only.
    always_ff @(posedge clk) begin
        if (dat_wr && in_range) begin
            mem[pos_q[WA_W-1:0]] <= wdata_i;
        end
    end

    // Purpose: prefetch the word at the next position, forwarding a same-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q <= '0;
        end else if (!nxt_in_range) begin
            pf_q <= '0;
        end else if (dat_wr && in_range && (pos_d == pos_q)) begin
            pf_q <= wdata_i;
        end else begin
            pf_q <= mem[pos_d[WA_W-1:0]];
        end
    end

    imp_tag_table #(.BLOCKS(BLOCKS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (tag_wr),
        .set_val_i  (wdata_i[TAG_W-1:0]),
        .fill_i     (fill && IS_CODE),
        .fill_blk_i (pos_q[CA_W-1:6]),
        .fill_sec_i (mode_q.secure),
        .look_blk_i (pos_q[CA_W-1:6]),
        .entry_o    (tag_view)
    );

    // Purpose: control readback layout and read-side selection.
    always_comb begin
        ctl_view                = '0;
        ctl_view[POS_HI:POS_LO] = pos_q;
        ctl_view[BIT_ADV_WR]    = mode_q.adv_wr;
        ctl_view[BIT_ADV_RD]    = mode_q.adv_rd;
        ctl_view[BIT_SECURE]    = mode_q.secure;
        rd_hit_o = !we_i && (ctl_sel || dat_sel || tag_sel);
        if (ctl_sel)      rd_val_o = ctl_view;
        else if (dat_sel) rd_val_o = pf_q;
        else              rd_val_o = tag_view;
    end

    assign err_o = err_q;

    // R7: the error flag never clears on its own
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    // R7: an out-of-range data access leaves the position alone and flags
    assert_oor_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dat_wr || dat_rd) && !in_range) |=> (pos_q == $past(pos_q)) && err_q);
    // R6: advancing from the last word lands on word 0
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !ctl_wr && pos_q == LAST) |=> pos_q == '0);
    // R3: an advancing access below the last word moves exactly one word
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !ctl_wr && pos_q != LAST) |=> pos_q == $past(pos_q) + 1'b1);
    // R9: the data window never reports a secure mark
    assert_nosec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !IS_CODE |-> !ctl_view[BIT_SECURE]);
endmodule

// File: rtl/imp_top.sv
// Top of the indirect memory window: a data-memory window, an instruction-
// memory window with tags and secure marks, the size register and the
// registered read path. Assumes at most one host request per cycle.
module imp_top
    import imp_pkg::*;
#(
    parameter int DM_BLOCKS = 4,
    parameter int IM_BLOCKS = 4,
    parameter int TAG_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [2:0]  reg_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        err_o
);
    localparam logic [31:0] CFG_VAL = {16'(IM_BLOCKS), 16'(DM_BLOCKS)};

    logic        dm_hit, im_hit, cfg_hit;
    logic [31:0] dm_val, im_val;
    logic        dm_err, im_err;
    logic [31:0] rdata_q;

    imp_window #(
        .BLOCKS(DM_BLOCKS), .IS_CODE(1'b0), .TAG_W(TAG_W),
        .CTL_IDX(SEL_DCTL), .DAT_IDX(SEL_DDAT), .TAG_IDX(SEL_TAG)
    ) u_dwin (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .reg_i(reg_i),
        .wdata_i(wdata_i), .rd_hit_o(dm_hit), .rd_val_o(dm_val), .err_o(dm_err)
    );

    imp_window #(
        .BLOCKS(IM_BLOCKS), .IS_CODE(1'b1), .TAG_W(TAG_W),
        .CTL_IDX(SEL_ICTL), .DAT_IDX(SEL_IDAT), .TAG_IDX(SEL_TAG)
    ) u_iwin (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .reg_i(reg_i),
        .wdata_i(wdata_i), .rd_hit_o(im_hit), .rd_val_o(im_val), .err_o(im_err)
    );

    assign cfg_hit = req_i && !we_i && (reg_i == SEL_CFG);

    // Purpose: register the selected read value; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (req_i && !we_i) begin
            if (dm_hit)       rdata_q <= dm_val;
            else if (im_hit)  rdata_q <= im_val;
            else if (cfg_hit) rdata_q <= CFG_VAL;
            else              rdata_q <= '0;
        end
    end

    assign rdata_o = rdata_q;
    assign err_o   = dm_err | im_err;

    // R12: a read is claimed by at most one source
    assert_one_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dm_hit, im_hit, cfg_hit}));
    // R5: read data only changes after a read request
    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !we_i) |=> $stable(rdata_q));
endmodule

// File: tb/imp_top_tb.sv
module imp_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] AW  = 32'h0100_0000;
    localparam logic [31:0] AR  = 32'h0200_0000;
    localparam logic [31:0] SEC = 32'h1000_0000;

    typedef struct packed {
        logic        we;
        logic [2:0]  rg;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, AW | 32'h140, 1'b0, 32'h0, 4'd3},       // R3 fill start
        '{1'b1, 3'd1, 32'hA000_0000, 1'b0, 32'h0, 4'd3},
        '{1'b1, 3'd1, 32'hA000_0001, 1'b0, 32'h0, 4'd3},
        '{1'b1, 3'd1, 32'hA000_0002, 1'b0, 32'h0, 4'd3},
        '{1'b0, 3'd0, 32'h0, 1'b1, AW | 32'h14C, 4'd3},       // R3 readback
        '{1'b1, 3'd0, AR | 32'h140, 1'b0, 32'h0, 4'd5},
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hA000_0000, 4'd5},      // R5 after ctl
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hA000_0001, 4'd4},      // R4 advance
        '{1'b0, 3'd0, 32'h0, 1'b1, AR | 32'h148, 4'd4},
        '{1'b1, 3'd0, 32'h144, 1'b0, 32'h0, 4'd4},
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hA000_0001, 4'd4},      // R4 hold
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hA000_0001, 4'd4},
        '{1'b1, 3'd1, 32'hB000_0000, 1'b0, 32'h0, 4'd4},
        '{1'b0, 3'd0, 32'h0, 1'b1, 32'h0000_0144, 4'd4},
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hB000_0000, 4'd5},      // R5 after write
        '{1'b0, 3'd5, 32'h0, 1'b1, 32'h0004_0004, 4'd11},     // R11 sizes
        '{1'b1, 3'd4, 32'h0000_0050, 1'b0, 32'h0, 4'd10},
        '{1'b1, 3'd2, SEC | AW | 32'h200, 1'b0, 32'h0, 4'd9},
        '{1'b0, 3'd2, 32'h0, 1'b1, SEC | AW | 32'h200, 4'd9}, // R9 secure readback
        '{1'b1, 3'd3, 32'hC000_0000, 1'b0, 32'h0, 4'd10},
        '{1'b0, 3'd4, 32'h0, 1'b1, 32'h8000_0050, 4'd10},     // R10 tag+secure
        '{1'b1, 3'd2, AR | 32'h200, 1'b0, 32'h0, 4'd12},
        '{1'b0, 3'd3, 32'h0, 1'b1, 32'hC000_0000, 4'd12},     // R12 code word
        '{1'b0, 3'd1, 32'h0, 1'b1, 32'hB000_0000, 4'd12},     // R12 data intact
        '{1'b1, 3'd0, SEC, 1'b0, 32'h0, 4'd9},
        '{1'b0, 3'd0, 32'h0, 1'b1, 32'h0, 4'd9}               // R9 no secure on data
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [2:0]  reg_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    imp_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .reg_i(reg_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic do_op(input logic we, input logic [2:0] rg, input logic [31:0] wd);
        @(negedge clk);
        req_i = 1'b1; we_i = we; reg_i = rg; wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] rg, input string rq, input logic [31:0] exp);
        do_op(1'b0, rg, 32'h0);
        check(rq, rdata_o, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1", rdata_o, 32'h0);
        check("R1", {31'b0, err_o}, 32'h0);
        rd_chk(3'd0, "R1", 32'h0);
        rd_chk(3'd2, "R1", 32'h0);
        rd_chk(3'd4, "R1", 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].we, VECS[i].rg, VECS[i].wd);
            if (VECS[i].chk) check($sformatf("R%0d vec %0d", VECS[i].rq, i), rdata_o, VECS[i].exp);
        end
        check("R7 no error on legal traffic", {31'b0, err_o}, 32'h0);

        // R2 field layout: block 3, word 5
        do_op(1'b1, 3'd0, AR | 32'h0000_0314);
        rd_chk(3'd0, "R2", AR | 32'h0000_0314);

        // R5 back-to-back reads of 0x140 then 0x144
        do_op(1'b1, 3'd0, AR | 32'h140);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; reg_i = 3'd1;
        @(negedge clk);
        check("R5 first", rdata_o, 32'hA000_0000);
        @(negedge clk);
        req_i = 1'b0;
        check("R5 second", rdata_o, 32'hB000_0000);

        // R10 consecutive tags across a block boundary
        do_op(1'b1, 3'd4, 32'h0000_0010);
        do_op(1'b1, 3'd2, AW | 32'h000);
        for (int k = 0; k < 65; k++) do_op(1'b1, 3'd3, 32'(k));
        rd_chk(3'd2, "R3 long fill", AW | 32'h104);
        do_op(1'b1, 3'd2, 32'h100);
        rd_chk(3'd4, "R10 block1", 32'h0000_0011);
        do_op(1'b1, 3'd2, 32'h000);
        rd_chk(3'd4, "R10 block0", 32'h0000_0010);

        // R6 wrap at the last word
        do_op(1'b1, 3'd0, AW | 32'h3FC);
        do_op(1'b1, 3'd1, 32'hD000_0000);
        rd_chk(3'd0, "R6 write wrap", AW);
        do_op(1'b1, 3'd0, AR | 32'h3FC);
        rd_chk(3'd1, "R6 last word", 32'hD000_0000);
        rd_chk(3'd0, "R6 read wrap", AR);

        // R7 out of range
        do_op(1'b1, 3'd0, AW | 32'h000);
        do_op(1'b1, 3'd1, 32'hE000_0000);
        check("R7 before", {31'b0, err_o}, 32'h0);
        do_op(1'b1, 3'd0, AW | 32'h400);
        do_op(1'b1, 3'd1, 32'hE000_0001);
        check("R7 flag", {31'b0, err_o}, 32'h1);
        rd_chk(3'd0, "R7 no move", AW | 32'h400);
        do_op(1'b1, 3'd0, AR | 32'h400);
        rd_chk(3'd1, "R7 read zero", 32'h0);
        do_op(1'b1, 3'd0, 32'h000);
        rd_chk(3'd1, "R7 no alias", 32'hE000_0000);
        check("R7 sticky", {31'b0, err_o}, 32'h1);

        // R8 misaligned control write
        do_reset();
        check("R8 clear", {31'b0, err_o}, 32'h0);
        do_op(1'b1, 3'd0, 32'h0000_0046);
        check("R8 flag", {31'b0, err_o}, 32'h1);
        rd_chk(3'd0, "R8 position", 32'h0000_0044);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule